// File: doc/BRIEF.md
# Clock-Synchronous Serial Master Transceiver

This block is a byte-wide serial master that works on a clock it generates itself. For each transfer it drives a transfer clock, shifts one byte out on a transmit line and, in the same transfer, samples one byte from a receive line. The transfer clock comes from the system clock through a programmable divider. A single polarity bit sets two things together: the level the clock rests at between transfers, and which of its edges launch and capture data. Two more controls set the bit order on the wire and whether the data levels are inverted.

Software uses a small write port with three registers: a control word, a transmit data byte and a divider value. It reads the status and the received byte directly from output ports, and it acknowledges a received byte with a one-cycle strobe. The control word holds a three-bit mode field. Any value other than the synchronous mode turns the interface off. While the interface is off, it drops the clock to idle, aborts any transfer and flushes both buffers. Writing the synchronous mode again brings the interface back after an error. A clean reset of the transmit side takes three writes: turn the mode off, select the synchronous mode again, then write transmit-enable to 1. The receive side is reset the same way, except that receive-enable is cleared before the mode is turned off.

Top module: `csio_master`

## Requirements
- R1: A transfer makes exactly 16 transfer-clock edges, which alternate between launch and capture and begin with a launch. Each launch/capture pair moves one bit, so a transfer moves 8 bits. Every half period lasts DIV+1 system clocks. DIV is latched when the transfer starts. After the last capture the clock is idle.
- R2: With polarity 0 the clock rests high, data launches on falling edges and is captured on rising edges. With polarity 1 the clock rests low, data launches on rising edges and is captured on falling edges. The clock returns to its resting level at the end of a transfer.
- R3: The transmit line changes only at launch edges. The k-th bit on the wire (k = 0..7) is data bit k when the order control (control bit 4) is 0, and data bit 7-k when it is 1. The result is XORed with the inversion control (control bit 5).
- R4: The k-th bit sampled from the receive line is XORed with the inversion control. It is then stored at bit position k of the received byte when the order control is 0, and at position 7-k when it is 1.
- R5: A transfer starts only when the interface is in synchronous mode, transmit-enable is 1 and the transmit buffer holds a byte. Starting takes the byte and sets the buffer-empty flag.
- R6: A write to the transmit data register (address 1) in synchronous mode clears the buffer-empty flag. While the interface is off, such a write is ignored.
- R7: At the end of a transfer with receive-enable set, the received byte appears on rx_data and rx_full goes to 1. With receive-enable clear, rx_full stays 0 and rx_data keeps its value.
- R8: A pulse on rx_ack clears rx_full.
- R9: The control register is at address 0 and its mode field is bits 2:0. Any mode other than 3'b001 turns the interface off. Within one cycle this stops the transfer, returns the clock to rest, drives the transmit line high, sets the buffer-empty flag, clears rx_full and zeroes rx_data.
- R10: Transmit-enable (control bit 6) and receive-enable (control bit 7) take the written value only when the same write selects mode 3'b001; otherwise they become 0. After the mode is selected again, each enable reads 0 until it is written to 1.
- R11: After reset the mode is off, the clock is high, the transmit line is high, busy and rx_full are 0, buffer-empty is 1 and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 transmit data, 2 divider |
| wr_data | input | 8 | Write data |
| rx_ack | input | 1 | Acknowledge the received byte (clears rx_full) |
| rxd | input | 1 | Serial receive line |
| sclk | output | 1 | Transfer clock |
| txd | output | 1 | Serial transmit line |
| busy | output | 1 | Transfer in progress |
| tx_empty | output | 1 | Transmit buffer holds no byte |
| rx_full | output | 1 | A received byte is waiting |
| rx_data | output | 8 | Last received byte |
| tx_enabled | output | 1 | Transmit-enable state |
| rx_enabled | output | 1 | Receive-enable state |

## Verification
The assertions assume that software does not rewrite the polarity, order or inversion controls while a transfer is running. The clock's return to rest is checked against the polarity latched at the start of the transfer. They also assume that the receive line changes only after a launch edge, so it is stable at every capture. The bench rewrites the control word only while busy is low. Its slave model drives the receive line one nanosecond after each launch edge it sees on sclk. The one exception is the abort test, which turns the mode off in the middle of a transfer on purpose; no assertion depends on the latched configuration across that abort.

// File: rtl/csio_pkg.sv
package csio_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  localparam logic [2:0] MODE_SYNC = 3'b001;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_TXD  = 2'd1;
  localparam logic [1:0] A_DIV  = 2'd2;

  // Control word, first field is the top bit.
  typedef struct packed {
    logic       rx_en;
    logic       tx_en;
    logic       inv;
    logic       msb_first;
    logic       pol;
    logic [2:0] mode;
  } ctrl_t;

  // Position in the data byte of the k-th bit on the wire.
  function automatic logic [IDX_W-1:0] data_pos(input logic [IDX_W-1:0] k,
                                                input logic msb);
    return msb ? (LAST_IDX - k) : k;
  endfunction

  // Line level for the k-th wire bit of a byte.
  function automatic logic wire_level(input logic [BYTE_W-1:0] b,
                                      input logic [IDX_W-1:0] k,
                                      input logic msb, input logic inv);
    return b[data_pos(k, msb)] ^ inv;
  endfunction

  // Place a sampled line level into the receive accumulator.
  function automatic logic [BYTE_W-1:0] insert_bit(input logic [BYTE_W-1:0] acc,
                                                   input logic [IDX_W-1:0] k,
                                                   input logic msb, input logic inv,
                                                   input logic lvl);
    logic [BYTE_W-1:0] r;
    r = acc;
    r[data_pos(k, msb)] = lvl ^ inv;
    return r;
  endfunction
endpackage

// File: rtl/csio_regs.sv
module csio_regs
  import csio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rx_ack,
  input  logic              start,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_word,
  output ctrl_t             ctrl,
  output logic              active,
  output logic              start_req,
  output logic [DIV_W-1:0]  div,
  output logic [BYTE_W-1:0] tx_buf,
  output logic              tx_empty,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_full
);
  ctrl_t ctrl_wr;
  logic  wr_ctrl, wr_txd, wr_div;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_txd  = wr_en && (wr_addr == A_TXD);
  assign wr_div  = wr_en && (wr_addr == A_DIV);

  // Enables only survive a write that selects the synchronous mode.
  always_comb begin
    ctrl_wr = ctrl_t'(wr_data);
    if (ctrl_wr.mode != MODE_SYNC) begin
      ctrl_wr.tx_en = 1'b0;
      ctrl_wr.rx_en = 1'b0;
    end
  end

  assign active    = (ctrl.mode == MODE_SYNC);
  assign start_req = ctrl.tx_en && !tx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      div      <= '0;
      tx_buf   <= '0;
      tx_empty <= 1'b1;
      rx_data  <= '0;
      rx_full  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_wr;
      if (wr_div)  div  <= wr_data[DIV_W-1:0];
      if (!active) begin
        tx_buf   <= '0;
        tx_empty <= 1'b1;
        rx_data  <= '0;
        rx_full  <= 1'b0;
      end else begin
        if (start) tx_empty <= 1'b1;
        if (wr_txd) begin
          tx_buf   <= wr_data;
          tx_empty <= 1'b0;
        end
        if (rx_ack) rx_full <= 1'b0;
        if (done && ctrl.rx_en) begin
          rx_data <= rx_word;
          rx_full <= 1'b1;
        end
      end
    end
  end

  AST_TX_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    active && wr_txd |=> !tx_empty); // R6
  AST_OFF_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> tx_empty && !rx_full && (rx_data == '0)); // R9
  AST_DONE_DELIVERS: assert property (@(posedge clk) disable iff (!rst_n)
    active && done && ctrl.rx_en |=> rx_full && (rx_data == $past(rx_word))); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    active && rx_ack && !done |=> !rx_full); // R8
  AST_ENABLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && (wr_data[2:0] != MODE_SYNC) |=> !ctrl.tx_en && !ctrl.rx_en); // R10
endmodule

// File: rtl/csio_clkgen.sv
module csio_clkgen
  import csio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             start_req,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             phase,
  output logic             start,
  output logic             launch,
  output logic             capture,
  output logic             done,
  output logic [IDX_W-1:0] bit_idx
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_l;
  logic             tick;

  assign start   = active && !busy && start_req;
  assign tick    = busy && (cnt == div_l);
  assign launch  = tick && !phase;
  assign capture = tick && phase;
  assign done    = capture && (bit_idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      cnt     <= '0;
      div_l   <= '0;
      bit_idx <= '0;
    end else if (!active) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      cnt     <= '0;
      bit_idx <= '0;
    end else if (start) begin
      // the start edge is itself the first launch edge
      busy    <= 1'b1;
      phase   <= 1'b1;
      cnt     <= '0;
      div_l   <= div;
      bit_idx <= '0;
    end else if (busy) begin
      if (tick) begin
        cnt   <= '0;
        phase <= ~phase;
        if (phase) begin
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == LAST_IDX) busy <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req) && $past(active)); // R5
  AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    active && busy && !tick |=> $stable(phase)); // R1
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    active && done |=> !busy && !phase); // R1
  AST_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !busy); // R9
endmodule

// File: rtl/csio_shifter.sv
module csio_shifter
  import csio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              start,
  input  logic              launch,
  input  logic              capture,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [BYTE_W-1:0] tx_buf,
  input  logic              pol_cfg,
  input  logic              msb_cfg,
  input  logic              inv_cfg,
  input  logic              rxd,
  output logic              txd,
  output logic              lat_pol,
  output logic [BYTE_W-1:0] rx_word
);
  logic [BYTE_W-1:0] lat_byte;
  logic [BYTE_W-1:0] acc;
  logic              lat_msb, lat_inv;

  // accumulator with the bit being captured this cycle merged in
  assign rx_word = insert_bit(acc, bit_idx, lat_msb, lat_inv, rxd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd      <= 1'b1;
      lat_byte <= '0;
      lat_pol  <= 1'b0;
      lat_msb  <= 1'b0;
      lat_inv  <= 1'b0;
      acc      <= '0;
    end else if (!active) begin
      txd <= 1'b1;
    end else if (start) begin
      lat_byte <= tx_buf;
      lat_pol  <= pol_cfg;
      lat_msb  <= msb_cfg;
      lat_inv  <= inv_cfg;
      acc      <= '0;
      txd      <= wire_level(tx_buf, '0, msb_cfg, inv_cfg);
    end else begin
      if (launch)  txd <= wire_level(lat_byte, bit_idx, lat_msb, lat_inv);
      if (capture) acc <= rx_word;
    end
  end

  AST_TXD_HOLD_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    active && capture |=> $stable(txd)); // R3
  AST_TXD_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> txd); // R9
endmodule

// File: rtl/csio_master.sv
module csio_master
  import csio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rx_ack,
  input  logic              rxd,
  output logic              sclk,
  output logic              txd,
  output logic              busy,
  output logic              tx_empty,
  output logic              rx_full,
  output logic [BYTE_W-1:0] rx_data,
  output logic              tx_enabled,
  output logic              rx_enabled
);
  ctrl_t             ctrl;
  logic              active, start_req, start, launch, capture, done, phase, lat_pol;
  logic [DIV_W-1:0]  div;
  logic [BYTE_W-1:0] tx_buf, rx_word;
  logic [IDX_W-1:0]  bit_idx;

  csio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_ack(rx_ack), .start(start), .done(done), .rx_word(rx_word),
    .ctrl(ctrl), .active(active), .start_req(start_req), .div(div),
    .tx_buf(tx_buf), .tx_empty(tx_empty), .rx_data(rx_data), .rx_full(rx_full)
  );

  csio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .active(active), .start_req(start_req), .div(div),
    .busy(busy), .phase(phase), .start(start), .launch(launch),
    .capture(capture), .done(done), .bit_idx(bit_idx)
  );

  csio_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .active(active), .start(start), .launch(launch),
    .capture(capture), .bit_idx(bit_idx), .tx_buf(tx_buf),
    .pol_cfg(ctrl.pol), .msb_cfg(ctrl.msb_first), .inv_cfg(ctrl.inv),
    .rxd(rxd), .txd(txd), .lat_pol(lat_pol), .rx_word(rx_word)
  );

  // phase 1 = after a launch edge; rest level is high for polarity 0
  assign sclk       = busy ? (phase ^ ~lat_pol) : ~ctrl.pol;
  assign tx_enabled = ctrl.tx_en;
  assign rx_enabled = ctrl.rx_en;

  AST_SCLK_RESTS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    active && done |=> sclk == ~lat_pol); // R2
endmodule

// File: tb/tb_csio_master.sv
`timescale 1ns/1ps
module tb_csio_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rx_ack = 1'b0;
  logic       rxd = 1'b0;
  logic       sclk, txd, busy, tx_empty, rx_full, tx_enabled, rx_enabled;
  logic [7:0] rx_data;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  csio_master dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_ack(rx_ack), .rxd(rxd), .sclk(sclk), .txd(txd), .busy(busy),
    .tx_empty(tx_empty), .rx_full(rx_full), .rx_data(rx_data),
    .tx_enabled(tx_enabled), .rx_enabled(rx_enabled)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [7:0] exp_wire(input logic [7:0] b, input bit msb, input bit inv);
    return (msb ? rev8(b) : b) ^ {8{inv}};
  endfunction

  function automatic logic [7:0] exp_rx(input logic [7:0] raw, input bit msb, input bit inv);
    logic [7:0] v;
    v = raw ^ {8{inv}};
    return msb ? rev8(v) : v;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
  endtask

  // slave model: drives raw wire bits after launches, records txd at captures
  task automatic slave(input bit pol, input logic [7:0] raw,
                       output logic [7:0] seen, output longint dt);
    longint tl, tc;
    tl = 0; tc = 0;
    for (int k = 0; k < 8; k++) begin
      if (pol) @(posedge sclk); else @(negedge sclk);
      if (k == 0) tl = $time;
      #1 rxd = raw[k];
      if (pol) @(negedge sclk); else @(posedge sclk);
      if (k == 0) tc = $time;
      seen[k] = txd;
    end
    dt = tc - tl;
  endtask

  task automatic do_xfer(input bit pol, input bit msb, input bit inv, input logic [7:0] dv,
                         input logic [7:0] tx, input logic [7:0] raw, input bit rxen);
    logic [7:0] seen, prev;
    longint dt;
    prev = rx_data;
    wr(2'd2, dv);
    wr(2'd0, {rxen, 1'b1, inv, msb, pol, 3'b001});
    fork
      slave(pol, raw, seen, dt);
      begin
        wr(2'd1, tx);
        @(negedge busy);
      end
    join
    @(negedge clk);
    chk("R3 wire bits", seen, exp_wire(tx, msb, inv));
    chk("R1 half period", dt, (longint'(dv) + 1) * 4);
    chk("R2 clock rest level", sclk, !pol);
    chk("R5 buffer empty after start", tx_empty, 1);
    if (rxen) begin
      chk("R4 received byte", rx_data, exp_rx(raw, msb, inv));
      chk("R7 rx_full set", rx_full, 1);
      ack();
      chk("R8 ack clears rx_full", rx_full, 0);
    end else begin
      chk("R7 rx_full stays clear", rx_full, 0);
      chk("R7 rx_data kept", rx_data, prev);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 sclk", sclk, 1);
    chk("R11 txd", txd, 1);
    chk("R11 busy", busy, 0);
    chk("R11 tx_empty", tx_empty, 1);
    chk("R11 rx_full", rx_full, 0);
    chk("R11 tx_enabled", tx_enabled, 0);
    chk("R11 rx_enabled", rx_enabled, 0);

    // sweep polarity, order, inversion, divider and two patterns
    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 2; d++) begin
        for (int b = 0; b < 2; b++) begin
          logic [7:0] tx, raw;
          tx  = b ? (8'h01 << c) : 8'(8'hA5 + c * 29 + d * 7);
          raw = b ? (8'h80 >> c) : (~tx ^ 8'h3C);
          do_xfer(c[0], c[1], c[2], 8'(d * 2), tx, raw, 1'b1);
        end
      end
    end

    // receive disabled leaves rx_data and rx_full alone
    do_xfer(1'b0, 1'b0, 1'b0, 8'd1, 8'h3D, 8'hC6, 1'b1);
    do_xfer(1'b0, 1'b1, 1'b0, 8'd1, 8'h5E, 8'h19, 1'b0);

    // abort in the middle of a transfer
    wr(2'd2, 8'd3);
    wr(2'd0, 8'hC1);
    wr(2'd1, 8'h96);
    repeat (10) @(negedge clk);
    chk("R5 transfer running", busy, 1);
    wr(2'd0, 8'hC0);
    @(negedge clk);
    chk("R9 busy dropped", busy, 0);
    chk("R9 clock at rest", sclk, 1);
    chk("R9 txd high", txd, 1);
    chk("R9 buffer flushed", tx_empty, 1);
    chk("R9 rx_full cleared", rx_full, 0);
    chk("R9 rx_data zeroed", rx_data, 0);
    chk("R10 tx enable masked when off", tx_enabled, 0);
    chk("R10 rx enable masked when off", rx_enabled, 0);

    wr(2'd1, 8'h55);
    @(negedge clk);
    chk("R6 write ignored while off", tx_empty, 1);

    // recovery: mode back on, enables stay 0 until written
    wr(2'd0, 8'h01);
    @(negedge clk);
    chk("R10 tx enable after reselect", tx_enabled, 0);
    chk("R10 rx enable after reselect", rx_enabled, 0);
    wr(2'd1, 8'h77);
    chk("R6 write fills buffer", tx_empty, 0);
    repeat (20) @(negedge clk);
    chk("R5 no start without enable", busy, 0);
    chk("R5 clock idle without enable", sclk, 1);
    wr(2'd0, 8'h41);
    chk("R10 tx enable written", tx_enabled, 1);
    @(negedge clk);
    chk("R5 start after enable", busy, 1);
    chk("R5 start empties buffer", tx_empty, 1);
    @(negedge busy);
    @(negedge clk);
    chk("R7 no rx_full with receive off", rx_full, 0);
    chk("R2 rest level after recovery", sclk, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule